// File: doc/BRIEF.md
# Pre-adder multiply-accumulate datapath

This block is a signed multiply-accumulate datapath. Two 25-bit operands are first summed or differenced in a pre-adder. The 25-bit result is multiplied by an 18-bit signed operand, and the product goes into a 48-bit accumulator. A filter with symmetric coefficients can therefore fold each pair of mirrored taps into one multiply.

Control bits travel with every sample, so each cycle can choose its own behaviour:
- pre-adder add or subtract;
- the product, or a direct 48-bit operand that skips the multiplier;
- add to the accumulator, or load it;
- subtract the term instead of adding it;
- whether to add a neighbour's cascade value.

An input stage, a post-multiply stage and an output stage can each be kept or removed at build time. With the multiplier bypassed and a constant operand of 1, the datapath counts up or down.

Top module: `premac`

## Requirements
- R1: The product is the signed two's complement product of the 25-bit pre-adder result and the 18-bit signed `b_i`, sign-extended to 48 bits.
- R2: With `pre_sub_i`=0 the pre-adder result is `d_i + a_i`.
- R3: With `pre_sub_i`=1 the pre-adder result is `d_i - a_i`.
- R4: The pre-adder result keeps only its low 25 bits (it wraps); `d_i`=0xFFFFFF, `a_i`=1 gives -16777216.
- R5: With `load_i`=0, `neg_i`=0 and `casc_i`=0, the accumulator adds the selected term to its previous value.
- R6: With `load_i`=1, the previous accumulator value is discarded and replaced by the term (plus the cascade value if it is enabled).
- R7: With `neg_i`=1, the term is subtracted instead of added.
- R8: With `bypass_i`=1, the 48-bit `c_i` replaces the product as the term; with `bypass_i`=0, `c_i` has no effect.
- R9: With `casc_i`=1, `pcin_i` is added as well; with `casc_i`=0, `pcin_i` has no effect. `pcout_o` always equals `p_o`.
- R10: Accumulator arithmetic wraps modulo 2^48.
- R11: Operands and control bits reach the accumulator after `IN_REG+M_REG` clock edges. `pcin_i` is not delayed: it is taken on the edge that updates the accumulator. `p_o` shows the new value `OUT_REG` edges after that update.
- R12: An active-low asynchronous reset clears every pipeline register and the accumulator, so `p_o` reads 0.
- R13: With the multiplier bypassed and `c_i`=1, the block counts up when `neg_i`=0 and counts down when `neg_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 25 | Pre-adder operand, the one that is added or subtracted |
| d_i | input | 25 | Pre-adder base operand |
| b_i | input | 18 | Multiplier operand |
| c_i | input | 48 | Direct term used when the multiplier is bypassed |
| pcin_i | input | 48 | Cascade input from the previous instance |
| pre_sub_i | input | 1 | Pre-adder subtracts `a_i` |
| bypass_i | input | 1 | Select `c_i` instead of the product |
| load_i | input | 1 | Load the accumulator instead of adding to it |
| neg_i | input | 1 | Subtract the term |
| casc_i | input | 1 | Add `pcin_i` |
| p_o | output | 48 | Accumulator result |
| pcout_o | output | 48 | Cascade output |

## Verification
The bench builds two instances from the same stimulus. One keeps all three pipeline stages, so results appear four edges after their inputs; the other removes every stage, so results appear after a single edge. A cycle-by-cycle arithmetic model checks every output sample of both instances. The 32 control combinations are swept with corner operands and random `pcin_i` values. This covers, under both latencies, the pre-adder wrap, the largest product, the 48-bit wrap, the counter mode, and the alignment of the undelayed cascade input against the delayed cascade enable.

// File: rtl/premac_pkg.sv
package premac_pkg;
  typedef struct packed {
    logic pre_sub;
    logic bypass;
    logic load;
    logic neg;
    logic casc;
  } mac_ctrl_t;

  localparam int unsigned CTRL_W = $bits(mac_ctrl_t);
endpackage

// File: rtl/premac_stage.sv
module premac_stage #(
  parameter int unsigned W  = 8,
  parameter bit          EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= d_i;
  end

  // stage removed at build time: register is left unloaded
  assign q_o = EN ? q_q : d_i;
endmodule

// File: rtl/premac_mul.sv
module premac_mul #(
  parameter int unsigned AW = 25,
  parameter int unsigned BW = 18,
  parameter int unsigned PW = 48,
  localparam int unsigned PROD_W = AW + BW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [AW-1:0] a_i,
  input  logic signed [AW-1:0] d_i,
  input  logic signed [BW-1:0] b_i,
  input  logic        [PW-1:0] c_i,
  input  logic                 pre_sub_i,
  input  logic                 bypass_i,
  output logic        [PW-1:0] term_o
);
  logic signed [AW-1:0]     pre_s;
  logic signed [PROD_W-1:0] prod_s;

  // wraps to AW bits
  always_comb pre_s = pre_sub_i ? (d_i - a_i) : (d_i + a_i);

  always_comb
    prod_s = $signed({{BW{pre_s[AW-1]}}, pre_s}) * $signed({{AW{b_i[BW-1]}}, b_i});

  always_comb
    term_o = bypass_i ? c_i : {{(PW-PROD_W){prod_s[PROD_W-1]}}, prod_s};

  logic [PW-PROD_W:0] ext_bits;
  assign ext_bits = term_o[PW-1:PROD_W-1];

  // R1
  prod_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && pre_s != '0 && b_i != '0) |-> term_o[PW-1] == (pre_s[AW-1] ^ b_i[BW-1]));

  // R1
  prod_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bypass_i |-> ((&ext_bits) || (~|ext_bits)));
endmodule

// File: rtl/premac_acc.sv
module premac_acc #(
  parameter int unsigned PW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] term_i,
  input  logic [PW-1:0] pcin_i,
  input  logic          load_i,
  input  logic          neg_i,
  input  logic          casc_i,
  output logic [PW-1:0] acc_o
);
  logic [PW-1:0] acc_q, acc_d, base, addend, casc_v;

  always_comb begin
    base   = load_i ? '0 : acc_q;
    addend = neg_i ? (~term_i + 1'b1) : term_i;
    casc_v = casc_i ? pcin_i : '0;
    acc_d  = base + addend + casc_v;  // modulo 2^PW
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R6
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !neg_i && !casc_i) |=> acc_q == $past(term_i));

  // R13
  count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !neg_i && !casc_i && term_i == PW'(1)) |=> acc_q == $past(acc_q) + PW'(1));

  // R13
  count_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && neg_i && !casc_i && term_i == PW'(1)) |=> acc_q == $past(acc_q) - PW'(1));

  // R9
  casc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && casc_i && term_i == '0) |=> acc_q == $past(acc_q) + $past(pcin_i));
endmodule

// File: rtl/premac.sv
module premac
  import premac_pkg::*;
#(
  parameter int unsigned AW      = 25,
  parameter int unsigned BW      = 18,
  parameter int unsigned PW      = 48,
  parameter bit          IN_REG  = 1'b1,
  parameter bit          M_REG   = 1'b1,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] d_i,
  input  logic [BW-1:0] b_i,
  input  logic [PW-1:0] c_i,
  input  logic [PW-1:0] pcin_i,
  input  logic          pre_sub_i,
  input  logic          bypass_i,
  input  logic          load_i,
  input  logic          neg_i,
  input  logic          casc_i,
  output logic [PW-1:0] p_o,
  output logic [PW-1:0] pcout_o
);
  localparam int unsigned S1_W = CTRL_W + 2*AW + BW + PW;
  localparam int unsigned S2_W = 3 + PW;

  mac_ctrl_t     ctrl_in, ctrl1;
  logic [AW-1:0] a1, d1;
  logic [BW-1:0] b1;
  logic [PW-1:0] c1, term, term2, acc;
  logic [S1_W-1:0] s1_d, s1_q;
  logic [S2_W-1:0] s2_d, s2_q;
  logic load2, neg2, casc2;

  always_comb begin
    ctrl_in.pre_sub = pre_sub_i;
    ctrl_in.bypass  = bypass_i;
    ctrl_in.load    = load_i;
    ctrl_in.neg     = neg_i;
    ctrl_in.casc    = casc_i;
  end

  assign s1_d = {ctrl_in, a_i, d_i, b_i, c_i};

  premac_stage #(.W(S1_W), .EN(IN_REG)) u_in_stage (
    .clk_i, .rst_ni, .d_i(s1_d), .q_o(s1_q)
  );

  assign {ctrl1, a1, d1, b1, c1} = s1_q;

  premac_mul #(.AW(AW), .BW(BW), .PW(PW)) u_mul (
    .clk_i, .rst_ni,
    .a_i(a1), .d_i(d1), .b_i(b1), .c_i(c1),
    .pre_sub_i(ctrl1.pre_sub), .bypass_i(ctrl1.bypass),
    .term_o(term)
  );

  assign s2_d = {ctrl1.load, ctrl1.neg, ctrl1.casc, term};

  premac_stage #(.W(S2_W), .EN(M_REG)) u_m_stage (
    .clk_i, .rst_ni, .d_i(s2_d), .q_o(s2_q)
  );

  assign {load2, neg2, casc2, term2} = s2_q;

  // pcin_i joins at the accumulator stage, not delayed
  premac_acc #(.PW(PW)) u_acc (
    .clk_i, .rst_ni,
    .term_i(term2), .pcin_i(pcin_i),
    .load_i(load2), .neg_i(neg2), .casc_i(casc2),
    .acc_o(acc)
  );

  premac_stage #(.W(PW), .EN(OUT_REG)) u_out_stage (
    .clk_i, .rst_ni, .d_i(acc), .q_o(p_o)
  );

  assign pcout_o = p_o;

  // R11
  out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    OUT_REG |=> p_o == $past(acc));
endmodule

// File: tb/premac_test.sv
module premac_test;
  localparam int N = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [24:0] a_i, d_i;
  logic [17:0] b_i;
  logic [47:0] c_i, pcin_i;
  logic pre_sub_i, bypass_i, load_i, neg_i, casc_i;
  logic [47:0] p_m, pc_m, p_f, pc_f;

  premac #(.IN_REG(1'b1), .M_REG(1'b1), .OUT_REG(1'b1)) uut (
    .clk_i(clk), .rst_ni, .a_i, .d_i, .b_i, .c_i, .pcin_i,
    .pre_sub_i, .bypass_i, .load_i, .neg_i, .casc_i,
    .p_o(p_m), .pcout_o(pc_m)
  );

  premac #(.IN_REG(1'b0), .M_REG(1'b0), .OUT_REG(1'b0)) uut_flat (
    .clk_i(clk), .rst_ni, .a_i, .d_i, .b_i, .c_i, .pcin_i,
    .pre_sub_i, .bypass_i, .load_i, .neg_i, .casc_i,
    .p_o(p_f), .pcout_o(pc_f)
  );

  logic signed [24:0] aa [N];
  logic signed [24:0] dd [N];
  logic signed [17:0] bb [N];
  logic [47:0] cc [N];
  logic [47:0] pc [N];
  logic ps [N];
  logic by [N];
  logic ld [N];
  logic ng [N];
  logic cs [N];
  string tg [N];
  logic [47:0] acc_m [N];
  logic [47:0] acc_f [N];

  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [47:0] term_of(input int j);
    logic signed [24:0] pre;
    logic signed [47:0] pr;
    if (by[j]) return cc[j];
    pre = ps[j] ? dd[j] - aa[j] : dd[j] + aa[j];
    pr  = 48'(pre) * 48'(bb[j]);
    return pr;
  endfunction

  function automatic logic [47:0] step(input logic [47:0] acc, input int j, input int t);
    logic [47:0] base, tm;
    base = ld[j] ? 48'd0 : acc;
    tm   = ng[j] ? -term_of(j) : term_of(j);
    return base + tm + (cs[j] ? pc[t] : 48'd0);
  endfunction

  function automatic logic [24:0] pick25();
    case ($urandom % 6)
      0: return 25'd0;
      1: return 25'd1;
      2: return '1;
      3: return 25'h0FFFFFF;
      4: return 25'h1000000;
      default: return 25'($urandom);
    endcase
  endfunction

  function automatic logic [17:0] pick18();
    case ($urandom % 6)
      0: return 18'd0;
      1: return 18'd1;
      2: return '1;
      3: return 18'h1FFFF;
      4: return 18'h20000;
      default: return 18'($urandom);
    endcase
  endfunction

  task automatic set_op(input int i, input string tag, input logic s, input logic y,
                        input logic l, input logic n, input logic [24:0] a,
                        input logic [24:0] d, input logic [17:0] b, input logic [47:0] c);
    ps[i] = s; by[i] = y; ld[i] = l; ng[i] = n; cs[i] = 1'b0;
    aa[i] = a; dd[i] = d; bb[i] = b; cc[i] = c; tg[i] = tag;
  endtask

  task automatic build();
    for (int i = 0; i < N; i++) begin
      pc[i] = {16'($urandom), 32'($urandom)};
      set_op(i, "R5", 0, 0, 0, 0, 25'($urandom), 25'($urandom), 18'd0, 48'($urandom));
    end
    for (int i = 0; i < 4; i++) tg[i] = "R12";
    // R11: one distinctive load, then idle cycles that keep it
    set_op(4, "R11", 0, 1, 1, 0, 0, 0, 0, 48'h123);
    for (int i = 5; i < 8; i++) tg[i] = "R11";
    // R1 products with mixed signs
    set_op(8, "R1", 0, 0, 1, 0, 25'd3, 25'd0, -18'sd5, 48'hDEAD);
    set_op(9, "R1", 0, 0, 1, 0, -25'sd7, 25'd2, 18'h1FFFF, 48'd0);
    set_op(10, "R1", 1, 0, 1, 0, -25'sd1000, 25'd100, 18'h20000, 48'd0);
    // R4 pre-adder wrap, both directions
    set_op(11, "R4", 0, 0, 1, 0, 25'd1, 25'h0FFFFFF, 18'd1, 48'd0);
    set_op(12, "R4", 1, 0, 1, 0, 25'd1, 25'h1000000, -18'sd1, 48'd0);
    // R5 accumulate chain
    set_op(13, "R5", 0, 0, 1, 0, 25'd1, 25'd1, 18'd1, 48'd0);
    for (int i = 14; i < 18; i++)
      set_op(i, "R5", i[0], 0, 0, 0, 25'($urandom % 500) - 25'd250,
             25'($urandom % 500), 18'($urandom % 300) - 18'd150, 48'd0);
    // R10 wrap at 2^48 and largest product
    set_op(18, "R10", 0, 1, 1, 0, 0, 0, 0, 48'h7FFF_FFFF_FFFF);
    set_op(19, "R10", 0, 1, 0, 0, 0, 0, 0, 48'd1);
    set_op(20, "R10", 0, 1, 0, 0, 0, 0, 0, 48'h8000_0000_0000);
    set_op(21, "R1", 0, 0, 1, 0, 25'd0, 25'h1000000, 18'h20000, 48'd0);
    // R13 up/down counter
    set_op(22, "R13", 0, 1, 1, 0, 0, 0, 0, 48'd0);
    for (int i = 23; i < 29; i++) set_op(i, "R13", 0, 1, 0, 0, 0, 0, 0, 48'd1);
    for (int i = 29; i < 36; i++) set_op(i, "R13", 0, 1, 0, 1, 0, 0, 0, 48'd1);
    // sweep of all control combinations with corner operands
    for (int i = 36; i < N - 8; i++) begin
      logic [4:0] k;
      k = 5'(i);
      ps[i] = k[0]; by[i] = k[1]; ld[i] = k[2]; ng[i] = k[3]; cs[i] = k[4];
      aa[i] = pick25(); dd[i] = pick25(); bb[i] = pick18();
      cc[i] = {16'($urandom), 32'($urandom)};
      tg[i] = cs[i] ? "R9" : ld[i] ? "R6" : ng[i] ? "R7" : by[i] ? "R8" : ps[i] ? "R3" : "R2";
    end
  endtask

  task automatic model();
    logic [47:0] am, af;
    am = '0; af = '0;
    for (int t = 0; t < N; t++) begin
      if (t >= 2) am = step(am, t - 2, t);
      af = step(af, t, t);
      acc_m[t] = am;
      acc_f[t] = af;
    end
  endtask

  task automatic drive(input int i);
    a_i = aa[i]; d_i = dd[i]; b_i = bb[i]; c_i = cc[i]; pcin_i = pc[i];
    pre_sub_i = ps[i]; bypass_i = by[i]; load_i = ld[i]; neg_i = ng[i]; casc_i = cs[i];
  endtask

  task automatic compare(input int t);
    check({tg[t], " flat"}, p_f, acc_f[t]);
    if (t >= 3) check({tg[t-3], " piped"}, p_m, acc_m[t-1]);
    else        check("R12 piped", p_m, 48'd0);
    check("R9 pcout piped", pc_m, p_m);
    check("R9 pcout flat", pc_f, p_f);
  endtask

  initial begin
    build();
    model();
    drive(0);
    repeat (3) @(negedge clk);
    check("R12 reset piped", p_m, 48'd0);
    check("R12 reset flat", p_f, 48'd0);
    rst_ni = 1'b1;
    for (int t = 0; t < N; t++) begin
      @(negedge clk);
      if (t > 0) compare(t - 1);
      drive(t);
    end
    @(negedge clk);
    compare(N - 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule